// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block feeds a transmit MAC from a ring of descriptors held in shared memory. Software fills a descriptor with a length, flags and a buffer address, sets the owner bit, and then pulses `kick`, which acts as the write of the channel enable. The engine fetches descriptors in ring order. For each descriptor it owns, it reads the buffer in bounded bursts into a small word buffer and unpacks it into a byte stream with start and end markers. It then writes the descriptor back with the owner bit cleared and pulses `pkt_done`.

A per-frame sideband, `out_crc`, tells the MAC whether to append the frame check sequence. The engine does no padding and computes no CRC. If the MAC is ready for the next byte of a frame already under way and no byte is buffered, the frame is marked underrun in the written-back status. When the engine fetches a descriptor it does not own, it goes idle quietly. A kick that arrives while the engine is running is remembered, so a descriptor handed over at the last moment is not missed.

Each descriptor is two 32-bit words at word address `RING_BASE + 2*index`. Word 0 holds the length and status. Word 1 holds the byte address of the buffer, which is word aligned. Memory is one request/grant port. Read data arrives on `mem_rdata` in the cycle after a granted read.

Top module: `txring_fetch`

## Requirements
- R1: After reset, `busy`, `out_valid`, `mem_req` and `pkt_done` are all low.
- R2: A `kick` pulse starts fetching at the current ring index. Descriptor word 0 is decoded as follows:
  - length in bytes: bits 27:16
  - owner: bit 15
  - end of frame: bit 14
  - start of frame: bit 13
  - wrap: bit 12
  - underrun: bit 9
  - append-CRC request: bit 8
- R3: For an owned descriptor, exactly `length` bytes leave on `out_data`, in buffer order, with byte k of a word taken from bits 8k+7:8k. `out_first` marks the first byte only when the start-of-frame flag is set. `out_last` marks the final byte only when the end-of-frame flag is set.
- R4: `out_crc` equals the append-CRC bit (bit 8) of the current descriptor on every byte of that descriptor.
- R5: After the final byte is accepted, word 0 is written back. The owner bit is cleared, bit 9 holds the underrun result, and every other bit keeps its fetched value. `pkt_done` pulses for one cycle, the cycle after that write is granted.
- R6: After a descriptor with the wrap bit, the next fetch is at ring index 0. Otherwise it is at the next index.
- R7: A fetched descriptor whose owner bit is clear produces no bytes and no writeback. The engine then goes idle with `busy`, `mem_req` and `out_valid` low until the next kick.
- R8: A kick received while the engine is busy makes the engine fetch the descriptor again after it meets an unowned one. This covers a kick in the cycle in which that fetch decision is taken.
- R9: Buffer reads are issued in bursts of at most `BURST` consecutive granted word reads.
- R10: The underrun bit (bit 9) is set when, after the first byte of a descriptor is accepted and before its last, `out_ready` is high while `out_valid` is low. It is clear otherwise.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | One-cycle channel enable pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write (descriptor writeback) |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after a granted read |
| out_valid | output | 1 | Byte available |
| out_data | output | 8 | Frame byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Last byte of a frame |
| out_crc | output | 1 | Downstream should append the CRC |
| out_ready | input | 1 | Downstream accepts the byte |
| pkt_done | output | 1 | One-cycle pulse per written-back descriptor |
| busy | output | 1 | Engine is processing the ring |

## Verification
The bench builds the engine with an eight-entry index space, a ring that starts at word 32 and 8-word bursts. With these values a wrap descriptor in the middle of the ring takes the walk back to entry 0 within a few frames. Three memory conditions are exercised:
- An always-granting memory drives the normal path.
- A memory that grants only one request in six drains the word buffer mid-frame, which forces the underrun bit.
- Random downstream backpressure holds bytes in place.

The late-kick race is reproduced by setting the owner bit and kicking in the exact cycle after the fetch that read the descriptor as not owned.

// File: rtl/txring_fetch.sv
module txring_fetch #(
  parameter int AW        = 12,
  parameter int IDXW      = 4,
  parameter int RING_BASE = 0,
  parameter int BURST     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_first,
  output logic          out_last,
  output logic          out_crc,
  input  logic          out_ready,
  output logic          pkt_done,
  output logic          busy
);
  localparam int DEPTH = 2 * BURST;
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int BW    = $clog2(BURST + 1);

  typedef enum logic [2:0] {IDLE, D0, D0W, D1, D1W, DATA, WB} st_t;

  st_t            state;
  logic [IDXW-1:0] idx;
  logic [31:0]    d0;
  logic [AW-1:0]  buf_addr;
  logic [10:0]    wreq_left;
  logic [11:0]    bytes_left;
  logic [BW-1:0]  burst_left;
  logic           pend, started, und, kick_pend;
  logic [31:0]    fifo [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic [1:0]     bsel;

  logic [AW-1:0] desc_addr;
  logic [31:0]   head;
  logic          fire, push, pop, dgnt, start_burst;
  logic [BW-1:0] burst_load;

  assign desc_addr  = AW'(RING_BASE) + AW'({idx, 1'b0});
  assign busy       = state != IDLE;
  assign mem_req    = (state == D0) || (state == D1) || (state == WB) ||
                      (state == DATA && burst_left != '0);
  assign mem_we     = state == WB;
  assign mem_addr   = (state == DATA) ? buf_addr :
                      (state == D1)   ? desc_addr + AW'(1) : desc_addr;
  assign mem_wdata  = {d0[31:16], 1'b0, d0[14:10], und, d0[8:0]};

  assign head       = fifo[rp];
  assign out_valid  = state == DATA && cnt != '0;
  assign out_data   = head[{bsel, 3'b000} +: 8];
  assign out_first  = out_valid && d0[13] && !started;
  assign out_last   = out_valid && d0[14] && bytes_left == 12'd1;
  assign out_crc    = d0[8];

  assign fire        = out_valid && out_ready;
  assign pop         = fire && (bsel == 2'd3 || bytes_left == 12'd1);
  assign push        = pend;
  assign dgnt        = state == DATA && burst_left != '0 && mem_gnt;
  assign start_burst = state == DATA && burst_left == '0 && wreq_left != '0 &&
                       (int'(cnt) + int'(pend) + BURST) <= DEPTH;
  assign burst_load  = (wreq_left < 11'(BURST)) ? wreq_left[BW-1:0] : BW'(BURST);

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      idx        <= '0;
      d0         <= '0;
      buf_addr   <= '0;
      wreq_left  <= '0;
      bytes_left <= '0;
      burst_left <= '0;
      pend       <= 1'b0;
      started    <= 1'b0;
      und        <= 1'b0;
      kick_pend  <= 1'b0;
      wp         <= '0;
      rp         <= '0;
      cnt        <= '0;
      bsel       <= '0;
      pkt_done   <= 1'b0;
    end else begin
      pend      <= dgnt;
      pkt_done  <= state == WB && mem_gnt;
      kick_pend <= (kick_pend || kick) && !(state == D0 && mem_gnt);
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
      case (state)
        IDLE: if (kick || kick_pend) state <= D0;
        D0:   if (mem_gnt) state <= D0W;
        D0W: begin
          d0      <= mem_rdata;
          started <= 1'b0;
          und     <= 1'b0;
          state   <= mem_rdata[15] ? D1 : IDLE;
        end
        D1:   if (mem_gnt) state <= D1W;
        D1W: begin
          buf_addr   <= mem_rdata[AW+1:2];
          bytes_left <= d0[27:16];
          wreq_left  <= 11'((13'(d0[27:16]) + 13'd3) >> 2);
          bsel       <= '0;
          state      <= (d0[27:16] == 12'd0) ? WB : DATA;
        end
        DATA: begin
          if (start_burst) burst_left <= burst_load;
          if (dgnt) begin
            burst_left <= burst_left - BW'(1);
            wreq_left  <= wreq_left - 11'd1;
            buf_addr   <= buf_addr + AW'(1);
          end
          if (started && out_ready && !out_valid) und <= 1'b1;
          if (fire) begin
            started    <= 1'b1;
            bytes_left <= bytes_left - 12'd1;
            bsel       <= bsel + 2'd1;
            if (bytes_left == 12'd1) begin
              bsel  <= '0;
              state <= WB;
            end
          end
        end
        WB: if (mem_gnt) begin
          idx   <= d0[12] ? '0 : idx + IDXW'(1);
          state <= D0;
        end
        default: state <= IDLE;
      endcase
    end
  end

  logic [BW:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= dgnt ? run + (BW+1)'(1) : '0;
  end

  assert_burst_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run <= (BW+1)'(BURST));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  assert_wb_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[15]);
  assert_done_after_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(mem_req && mem_we && mem_gnt));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !out_valid);
endmodule

// File: tb/txring_fetch_test.sv
module txring_fetch_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10, IDXW = 3, RB = 32, BURST = 8;

  logic clk = 0, rst_n = 0, kick = 0;
  logic mem_req, mem_we, mem_gnt = 1, out_ready = 1;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic out_valid, out_first, out_last, out_crc, pkt_done, busy;
  logic [7:0] out_data;

  int tests = 0, fails = 0, done_cnt = 0;
  bit finished = 0;
  int gnt_mode = 0, rdy_mode = 0, slow = 0;
  logic [15:0] lf = 16'hACE1;
  logic [10:0] exp_q [$];

  logic [31:0] mem [0:(1<<AW)-1];
  logic hw_en = 0;
  logic [AW-1:0] hw_a;
  logic [31:0] hw_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  txring_fetch #(.AW(AW), .IDXW(IDXW), .RING_BASE(RB), .BURST(BURST)) uut (
    .clk(clk), .rst_n(rst_n), .kick(kick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .out_crc(out_crc), .out_ready(out_ready),
    .pkt_done(pkt_done), .busy(busy));

  always @(posedge clk) begin
    if (hw_en) mem[hw_a] <= hw_d;
    else if (mem_req && mem_gnt && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && mem_gnt && !mem_we) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    #1;
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    out_ready <= (rdy_mode == 0) ? 1'b1 : lf[3];
    slow <= (slow == 5) ? 0 : slow + 1;
    mem_gnt <= (gnt_mode == 0) ? 1'b1 : (slow == 5);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pkt_done) done_cnt++;
      if (out_valid && out_ready) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R3 unexpected byte: got %h expected none", out_data);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          if ({out_first, out_last, out_crc, out_data} !== e) begin
            fails++;
            $display("FAIL R3 R4 byte {first,last,crc,data}: got %b_%b_%b_%h expected %b_%b_%b_%h",
                     out_first, out_last, out_crc, out_data, e[10], e[9], e[8], e[7:0]);
          end
        end
      end
    end
  end

  function automatic logic [31:0] dw(int len, bit own, bit eop, bit sop, bit wrap, bit crc, bit un);
    return {4'b0, 12'(len), own, eop, sop, wrap, 2'b00, un, crc, 8'h00};
  endfunction

  task automatic hwr(int a, logic [31:0] d);
    @(posedge clk); #1;
    hw_en = 1; hw_a = AW'(a); hw_d = d;
    @(posedge clk); #1;
    hw_en = 0;
  endtask

  task automatic pulse_kick();
    @(posedge clk); #1; kick = 1;
    @(posedge clk); #1; kick = 0;
  endtask

  task automatic fill_buf(int bufw, int len, int seed);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] v;
      for (int k = 0; k < 4; k++) v[8*k +: 8] = 8'(seed * 7 + 4 * w + k);
      hwr(bufw + w, v);
    end
  endtask

  task automatic push_exp(int len, int seed, bit eop, bit sop, bit crc);
    for (int i = 0; i < len; i++)
      exp_q.push_back({sop && i == 0, eop && i == len - 1, crc, 8'(seed * 7 + i)});
  endtask

  task automatic set_desc(int idx, int len, bit eop, bit sop, bit wrap, bit crc, int bufw, int seed);
    fill_buf(bufw, len, seed);
    hwr(RB + 2 * idx + 1, 32'(bufw * 4));
    push_exp(len, seed, eop, sop, crc);
    hwr(RB + 2 * idx, dw(len, 1, eop, sop, wrap, crc, 0));
  endtask

  task automatic wait_done(int target, string tag);
    int c = 0;
    while ((done_cnt < target || exp_q.size() != 0) && c < 20000) begin
      @(negedge clk); c++;
    end
    repeat (10) @(negedge clk);
    tests++;
    if (done_cnt != target || exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s frames done: got %0d expected %0d (pending bytes %0d)", tag, done_cnt, target, exp_q.size());
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_idle(string tag);
    bit bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || mem_req || out_valid) bad = 1;
    end
    chk(tag, {29'b0, bad, 2'b0}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {28'b0, busy, out_valid, mem_req, pkt_done}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      hwr(RB + 2 * i, 32'h0);
      hwr(RB + 2 * i + 1, 32'h0);
    end

    // R2 R3 R4: single frame
    set_desc(0, 64, 1, 1, 0, 1, 64, 1);
    pulse_kick();
    wait_done(1, "R2");
    chk("R5 writeback idx0", mem[RB + 0], dw(64, 0, 1, 1, 0, 1, 0));
    chk("R7 unowned idx1 untouched", mem[RB + 2], 32'h0);
    chk_idle("R7 idle after unowned");

    // R3 split frame, odd lengths, per-descriptor crc
    set_desc(1, 65, 0, 1, 0, 0, 96, 2);
    set_desc(2, 70, 1, 0, 0, 1, 128, 3);
    pulse_kick();
    wait_done(3, "R3");
    chk("R5 writeback idx1", mem[RB + 2], dw(65, 0, 0, 1, 0, 0, 0));
    chk("R5 writeback idx2", mem[RB + 4], dw(70, 0, 1, 0, 0, 1, 0));

    // R6 wrap from idx3 back to idx0
    set_desc(3, 67, 1, 1, 1, 0, 160, 4);
    set_desc(0, 72, 1, 1, 0, 1, 192, 5);
    pulse_kick();
    wait_done(5, "R6");
    chk("R6 writeback idx3 keeps wrap", mem[RB + 6], dw(67, 0, 1, 1, 1, 0, 0));
    chk("R6 writeback idx0", mem[RB + 0], dw(72, 0, 1, 1, 0, 1, 0));
    chk("R6 idx4 untouched", mem[RB + 8], 32'h0);
    chk("R7 stop at idx1", mem[RB + 2], dw(65, 0, 0, 1, 0, 0, 0));

    // R11 random backpressure, no underrun
    rdy_mode = 1;
    set_desc(1, 100, 1, 1, 0, 1, 224, 6);
    pulse_kick();
    wait_done(6, "R11");
    chk("R10 no underrun under backpressure", mem[RB + 2], dw(100, 0, 1, 1, 0, 1, 0));
    rdy_mode = 0;

    // R10 slow memory drains the buffer mid-frame
    hwr(RB + 6, 32'h0);
    set_desc(2, 80, 1, 1, 0, 0, 256, 7);
    gnt_mode = 1;
    pulse_kick();
    wait_done(7, "R10");
    gnt_mode = 0;
    repeat (8) @(posedge clk);
    chk("R10 underrun bit set", mem[RB + 4], dw(80, 0, 1, 1, 0, 0, 1));

    // R8 kick during the cycle the unowned descriptor is judged
    hwr(RB + 8, 32'h0);
    hwr(RB + 10, 32'h0);
    fill_buf(320, 68, 9);
    hwr(RB + 9, 32'(320 * 4));
    set_desc(3, 64, 1, 1, 0, 1, 288, 8);
    pulse_kick();
    begin
      int c = 0;
      @(negedge clk);
      while (!(mem_req && !mem_we && mem_gnt && mem_addr == AW'(RB + 8)) && c < 5000) begin
        @(negedge clk); c++;
      end
    end
    @(posedge clk); #1;
    hw_en = 1; hw_a = AW'(RB + 8); hw_d = dw(68, 1, 1, 1, 0, 0, 0); kick = 1;
    push_exp(68, 9, 1, 1, 0);
    @(posedge clk); #1;
    hw_en = 0; kick = 0;
    wait_done(9, "R8");
    chk("R8 late descriptor written back", mem[RB + 8], dw(68, 0, 1, 1, 0, 0, 0));
    chk_idle("R7 idle at idx5");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule